// File: doc/BRIEF.md
# Triggered Latency Readout Buffer

This block keeps a rolling history of detector data, one entry per bunch crossing, in a circular pipeline. Each entry holds the raw front-end payload for that crossing (several link lanes wide), the trigger-primitive word computed from it, and the bunch-crossing number the crossing was given. When a trigger-accept pulse arrives, the block picks a window of consecutive crossings that starts a programmable number of crossings in the past. It queues the request and later streams the window out as one framed event.

An event goes out on a valid/ready stream, one lane-wide word per beat, in this order:
- a header word carrying the event number and the crossing number of the window's first crossing;
- the raw lanes of every crossing in the window;
- the primitive word of every crossing in the window;
- a trailer word carrying the event number and the event length.

Accepts that arrive during a readout wait in a small queue. When the queue is full, further accepts are discarded and counted.

Top module: `trig_readout_buf`

## Requirements
- R1: Each cycle with `xing_tick` high stores one crossing. An accept seen in a cycle when N crossings have been stored selects the window that starts at crossing N−`lat_cfg` (crossings numbered from 0 in store order) and spans `win_cfg` crossings. Valid settings are 1 ≤ `win_cfg` ≤ `lat_cfg` < 2^PTR_W.
- R2: The first word of an event is the header. Bits [31:28] hold 4'hA, bits [27:12] hold the event number, and bits [11:0] hold the crossing number of the window's first crossing.
- R3: The raw words follow the header. Crossings go oldest first, and within a crossing lane 0 comes first, where lane i is `raw_in[32*i+31:32*i]`.
- R4: After the raw words come the primitive words, one per crossing, oldest first.
- R5: The last word is the trailer. Bits [31:28] hold 4'hE, bits [27:12] hold the event number, and bits [11:0] hold the total word count 2 + `win_cfg`×(RAW_LANES+1). `ev_last` is high on the trailer and on no other word.
- R6: The crossing counter starts at 0 after reset. A crossing stored with `orbit_sync` high is numbered 0. Otherwise a crossing is numbered one more than the previous one, and 3563 is followed by 0.
- R7: The event number is 1 for the first queued accept after reset and rises by one for each queued accept. Dropped accepts do not advance it.
- R8: Up to QDEPTH accepts wait in the queue. `q_full` is high exactly when QDEPTH accepts are waiting, and an event leaves the queue in the idle cycle before its header is presented.
- R9: An accept seen while `q_full` is high is not queued, and `drop_count` rises by one. At all other times `drop_count` holds its value.
- R10: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_data` and `ev_last` hold. Each word is delivered exactly once.
- R11: `lat_cfg` and `win_cfg` are captured when the accept is seen. Changing them afterwards does not alter an event that is already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_tick | input | 1 | Stores the current crossing |
| orbit_sync | input | 1 | Marks the stored crossing as number 0 |
| raw_in | input | RAW_LANES*LANE_W | Raw front-end payload for the crossing |
| tp_in | input | LANE_W | Trigger-primitive word for the crossing |
| accept_in | input | 1 | Trigger-accept pulse |
| lat_cfg | input | PTR_W | Latency offset in crossings |
| win_cfg | input | WIN_W | Window length in crossings |
| ev_valid | output | 1 | Output word valid |
| ev_ready | input | 1 | Downstream ready |
| ev_data | output | LANE_W | Output word |
| ev_last | output | 1 | Marks the trailer word |
| q_full | output | 1 | Accept queue full |
| drop_count | output | 16 | Count of discarded accepts |

## Verification
The main function is tried with several patterns:
- single accepts under a free-running downstream, with minimum and maximum windows; these show that the window offset, word order and length fields are computed correctly;
- a train of back-to-back accepts under random ready, which fills the queue and shows that queued events survive while later accepts are dropped;
- a stretch of ready held low in the middle of an event, which separates correct holding of a word from a word that is lost or repeated;
- slowed crossing ticks, an orbit-sync crossing and a counter wrap at 3563, which show that the header crossing number follows the stored crossings rather than the clock;
- a configuration change right after an accept, which confirms that settings are captured per accept.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int BX_W   = 12;
  localparam int EVT_W  = 16;
  localparam int ORBIT  = 3564;
  localparam logic [3:0] HDR_TAG = 4'hA;
  localparam logic [3:0] TRL_TAG = 4'hE;

  typedef enum logic [2:0] {
    RD_IDLE = 3'd0,
    RD_HDR  = 3'd1,
    RD_RAW  = 3'd2,
    RD_TP   = 3'd3,
    RD_TRL  = 3'd4
  } rd_state_e;
endpackage

// File: rtl/lrb_bx_counter.sv
module lrb_bx_counter
  import lrb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            sync,
  output logic [BX_W-1:0] cur_bx
);
  logic [BX_W-1:0] bx_q, bx_d;

  assign cur_bx = sync ? '0 : bx_q;

  always_comb begin
    bx_d = bx_q;
    if (tick) bx_d = (cur_bx == BX_W'(ORBIT - 1)) ? '0 : cur_bx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bx_q <= '0;
    else        bx_q <= bx_d;
endmodule

// File: rtl/lrb_pipeline_mem.sv
module lrb_pipeline_mem #(
  parameter int PTR_W  = 9,
  parameter int DATA_W = 172
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q, ptr_d;

  assign ptr_d   = wr_en ? ptr_q + 1'b1 : ptr_q;
  assign wr_ptr  = ptr_q;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;

  always_ff @(posedge clk)
    if (wr_en) mem[ptr_q] <= wr_data;
endmodule

// File: rtl/lrb_start_fifo.sv
module lrb_start_fifo #(
  parameter int ENT_W = 29,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] wdata,
  input  logic             pop,
  output logic [ENT_W-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] slot [DEPTH];
  logic [IDX_W-1:0] wi_q, wi_d, ri_q, ri_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = slot[ri_q];

  always_comb begin
    wi_d  = wi_q;
    ri_d  = ri_q;
    cnt_d = cnt_q;
    if (do_push) wi_d = (wi_q == IDX_W'(DEPTH - 1)) ? '0 : wi_q + 1'b1;
    if (do_pop)  ri_d = (ri_q == IDX_W'(DEPTH - 1)) ? '0 : ri_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wi_q  <= '0;
      ri_q  <= '0;
      cnt_q <= '0;
    end else begin
      wi_q  <= wi_d;
      ri_q  <= ri_d;
      cnt_q <= cnt_d;
    end

  always_ff @(posedge clk)
    if (do_push) slot[wi_q] <= wdata;
endmodule

// File: rtl/lrb_event_reader.sv
module lrb_event_reader
  import lrb_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int RAW_LANES = 4,
  parameter int PTR_W     = 9,
  parameter int WIN_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ent_valid,
  input  logic [PTR_W-1:0]            ent_start,
  input  logic [WIN_W-1:0]            ent_win,
  input  logic [EVT_W-1:0]            ent_evt,
  output logic                        pop,
  output logic [PTR_W-1:0]            rd_addr,
  input  logic [RAW_LANES*LANE_W-1:0] rd_raw,
  input  logic [LANE_W-1:0]           rd_tp,
  input  logic [BX_W-1:0]             rd_bx,
  output logic                        ev_valid,
  input  logic                        ev_ready,
  output logic [LANE_W-1:0]           ev_data,
  output logic                        ev_last
);
  localparam int LN_W = (RAW_LANES > 1) ? $clog2(RAW_LANES) : 1;
  localparam logic [LN_W-1:0] LAST_LANE = LN_W'(RAW_LANES - 1);

  rd_state_e        st_q, st_d;
  logic [PTR_W-1:0] start_q, start_d;
  logic [WIN_W-1:0] win_q, win_d, k_q, k_d;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic [LN_W-1:0]  lane_q, lane_d;
  logic [BX_W-1:0]  wcount;
  logic [31:0]      hdr_w, trl_w;

  assign rd_addr  = start_q + PTR_W'(k_q);
  assign ev_valid = (st_q != RD_IDLE);
  assign ev_last  = (st_q == RD_TRL);
  assign wcount   = BX_W'(2 + int'(win_q) * (RAW_LANES + 1));
  assign hdr_w    = {HDR_TAG, evt_q, rd_bx};
  assign trl_w    = {TRL_TAG, evt_q, wcount};

  always_comb begin
    case (st_q)
      RD_HDR:  ev_data = LANE_W'(hdr_w);
      RD_RAW:  ev_data = rd_raw[int'(lane_q) * LANE_W +: LANE_W];
      RD_TP:   ev_data = rd_tp;
      RD_TRL:  ev_data = LANE_W'(trl_w);
      default: ev_data = '0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    start_d = start_q;
    win_d   = win_q;
    evt_d   = evt_q;
    k_d     = k_q;
    lane_d  = lane_q;
    pop     = 1'b0;
    case (st_q)
      RD_IDLE: if (ent_valid) begin
        pop     = 1'b1;
        st_d    = RD_HDR;
        start_d = ent_start;
        win_d   = ent_win;
        evt_d   = ent_evt;
        k_d     = '0;
        lane_d  = '0;
      end
      RD_HDR: if (ev_ready) st_d = RD_RAW;
      RD_RAW: if (ev_ready) begin
        if (lane_q == LAST_LANE) begin
          lane_d = '0;
          if (k_q == win_q - 1'b1) begin
            k_d  = '0;
            st_d = RD_TP;
          end else k_d = k_q + 1'b1;
        end else lane_d = lane_q + 1'b1;
      end
      RD_TP: if (ev_ready) begin
        if (k_q == win_q - 1'b1) st_d = RD_TRL;
        else                     k_d  = k_q + 1'b1;
      end
      RD_TRL: if (ev_ready) st_d = RD_IDLE;
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q    <= RD_IDLE;
      start_q <= '0;
      win_q   <= '0;
      evt_q   <= '0;
      k_q     <= '0;
      lane_q  <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      win_q   <= win_d;
      evt_q   <= evt_d;
      k_q     <= k_d;
      lane_q  <= lane_d;
    end
endmodule

// File: rtl/trig_readout_buf.sv
module trig_readout_buf
  import lrb_pkg::*;
#(
  parameter int LANE_W    = 32,
  parameter int RAW_LANES = 4,
  parameter int PTR_W     = 9,
  parameter int WIN_W     = 4,
  parameter int QDEPTH    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        xing_tick,
  input  logic                        orbit_sync,
  input  logic [RAW_LANES*LANE_W-1:0] raw_in,
  input  logic [LANE_W-1:0]           tp_in,
  input  logic                        accept_in,
  input  logic [PTR_W-1:0]            lat_cfg,
  input  logic [WIN_W-1:0]            win_cfg,
  output logic                        ev_valid,
  input  logic                        ev_ready,
  output logic [LANE_W-1:0]           ev_data,
  output logic                        ev_last,
  output logic                        q_full,
  output logic [15:0]                 drop_count
);
  localparam int RAW_W  = RAW_LANES * LANE_W;
  localparam int MEM_W  = RAW_W + LANE_W + BX_W;
  localparam int ENT_W  = PTR_W + WIN_W + EVT_W;

  logic [BX_W-1:0]  cur_bx, rd_bx;
  logic [PTR_W-1:0] wr_ptr, rd_addr, ent_start;
  logic [MEM_W-1:0] rd_word;
  logic [RAW_W-1:0] rd_raw;
  logic [LANE_W-1:0] rd_tp;
  logic [ENT_W-1:0] ent_w, ent_r;
  logic [WIN_W-1:0] ent_win;
  logic [EVT_W-1:0] ent_evt, evt_q, evt_d;
  logic [15:0]      drop_q, drop_d;
  logic             push, pop, empty, full;

  lrb_bx_counter i_bx (
    .clk(clk), .rst_n(rst_n), .tick(xing_tick), .sync(orbit_sync), .cur_bx(cur_bx)
  );

  lrb_pipeline_mem #(.PTR_W(PTR_W), .DATA_W(MEM_W)) i_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(xing_tick),
    .wr_data({raw_in, tp_in, cur_bx}), .wr_ptr(wr_ptr),
    .rd_addr(rd_addr), .rd_data(rd_word)
  );
  assign {rd_raw, rd_tp, rd_bx} = rd_word;

  assign push  = accept_in && !full;
  assign ent_w = {PTR_W'(wr_ptr - lat_cfg), win_cfg, EVT_W'(evt_q + 1'b1)};

  lrb_start_fifo #(.ENT_W(ENT_W), .DEPTH(QDEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(ent_w), .pop(pop),
    .rdata(ent_r), .empty(empty), .full(full)
  );
  assign {ent_start, ent_win, ent_evt} = ent_r;

  lrb_event_reader #(
    .LANE_W(LANE_W), .RAW_LANES(RAW_LANES), .PTR_W(PTR_W), .WIN_W(WIN_W)
  ) i_rd (
    .clk(clk), .rst_n(rst_n), .ent_valid(!empty), .ent_start(ent_start),
    .ent_win(ent_win), .ent_evt(ent_evt), .pop(pop), .rd_addr(rd_addr),
    .rd_raw(rd_raw), .rd_tp(rd_tp), .rd_bx(rd_bx), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_data(ev_data), .ev_last(ev_last)
  );

  assign evt_d  = push ? evt_q + 1'b1 : evt_q;
  assign drop_d = (accept_in && full) ? drop_q + 1'b1 : drop_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_q  <= '0;
      drop_q <= '0;
    end else begin
      evt_q  <= evt_d;
      drop_q <= drop_d;
    end

  assign q_full     = full;
  assign drop_count = drop_q;
endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
  parameter int LANE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept_in,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [LANE_W-1:0] ev_data,
  input logic              ev_last,
  input logic              q_full,
  input logic [15:0]       drop_count
);
  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_data) && $stable(ev_last));
  // R2
  hdr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> ev_data[31:28] == 4'hA && ev_data[11:0] < 12'd3564);
  // R5
  trl_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |-> ev_valid && ev_data[31:28] == 4'hE);
  // R9
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_in && q_full |=> drop_count == $past(drop_count) + 16'd1);
  // R9
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_in && q_full) |=> $stable(drop_count));
endmodule

bind trig_readout_buf lrb_checker #(.LANE_W(LANE_W)) i_lrb_chk (
  .clk(clk), .rst_n(rst_n), .accept_in(accept_in), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .ev_data(ev_data), .ev_last(ev_last),
  .q_full(q_full), .drop_count(drop_count)
);

// File: tb/test_trig_readout_buf.sv
module test_trig_readout_buf;
  localparam int LANE_W = 32, RAW_LANES = 4, PTR_W = 9, WIN_W = 4, QD = 4;

  logic clk = 1'b0;
  logic rst_n, xing_tick, orbit_sync, accept_in, ev_valid, ev_ready, ev_last, q_full;
  logic [RAW_LANES*LANE_W-1:0] raw_in;
  logic [LANE_W-1:0] tp_in, ev_data;
  logic [PTR_W-1:0] lat_cfg;
  logic [WIN_W-1:0] win_cfg;
  logic [15:0] drop_count;

  always #10 clk = ~clk;

  trig_readout_buf i_trig_readout_buf (.*);

  int vectors = 0, fails = 0;
  bit done = 0;
  int tick_div = 1, phase = 0, rdy_mode = 0;
  bit fire = 0, sync_req = 0;

  // reference model state
  logic [127:0] rawm [int];
  logic [31:0]  tpm  [int];
  logic [11:0]  bxm  [int];
  int n = 0, bxc = 0, evn = 0, drops = 0, n_sync = 0;
  int pq_s[$], pq_w[$], pq_e[$];
  logic [31:0] cur_w[$];
  string cur_t[$];

  task automatic load_event(int s, int w, int e);
    cur_w.push_back({4'hA, e[15:0], bxm[s]}); cur_t.push_back("R2");
    for (int c = 0; c < w; c++)
      for (int l = 0; l < RAW_LANES; l++) begin
        cur_w.push_back(rawm[s+c][l*32 +: 32]); cur_t.push_back("R3");
      end
    for (int c = 0; c < w; c++) begin
      cur_w.push_back(tpm[s+c]); cur_t.push_back("R4");
    end
    cur_w.push_back({4'hE, e[15:0], 12'(2 + w * (RAW_LANES + 1))}); cur_t.push_back("R5");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; bxc = 0; evn = 0; drops = 0;
      pq_s.delete(); pq_w.delete(); pq_e.delete(); cur_w.delete(); cur_t.delete();
    end else begin
      int pre_n, cb;
      pre_n = pq_s.size();
      if (cur_w.size() == 0) begin
        if (pre_n > 0) begin
          load_event(pq_s[0], pq_w[0], pq_e[0]);
          void'(pq_s.pop_front()); void'(pq_w.pop_front()); void'(pq_e.pop_front());
        end
      end else if (ev_ready) begin
        void'(cur_w.pop_front()); void'(cur_t.pop_front());
      end
      if (accept_in) begin
        if (pre_n < QD) begin
          evn++;
          pq_s.push_back(n - int'(lat_cfg)); pq_w.push_back(int'(win_cfg)); pq_e.push_back(evn);
        end else drops++;
      end
      if (xing_tick) begin
        cb = orbit_sync ? 0 : bxc;
        rawm[n] = raw_in; tpm[n] = tp_in; bxm[n] = 12'(cb);
        bxc = (cb == 3563) ? 0 : cb + 1;
        n++;
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit mv;
    mv = (cur_w.size() > 0);
    chk(ev_valid === mv, "R10", "ev_valid", 32'(ev_valid), 32'(mv));
    if (mv) begin
      chk(ev_data === cur_w[0], cur_t[0], "ev_data", ev_data, cur_w[0]);
      chk(ev_last === (cur_w.size() == 1), "R5", "ev_last", 32'(ev_last), 32'(cur_w.size() == 1));
    end
    chk(q_full === (pq_s.size() == QD), "R8", "q_full", 32'(q_full), 32'(pq_s.size() == QD));
    chk(drop_count === 16'(drops), "R9", "drop_count", 32'(drop_count), 32'(drops));
  endtask

  task automatic cyc(int k = 1);
    repeat (k) begin
      @(negedge clk);
      if (rst_n) compare();
      xing_tick = (phase == 0);
      phase = (phase + 1) % tick_div;
      raw_in = {$urandom, $urandom, $urandom, $urandom};
      tp_in = $urandom;
      orbit_sync = 1'b0;
      if (sync_req && xing_tick) begin
        orbit_sync = 1'b1; sync_req = 0; n_sync = n;
      end
      accept_in = fire;
      ev_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : 1'($urandom % 2);
    end
  endtask

  task automatic accept_now(int l, int w);
    lat_cfg = PTR_W'(l); win_cfg = WIN_W'(w);
    fire = 1; cyc(); fire = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; xing_tick = 0; orbit_sync = 0; accept_in = 0; ev_ready = 1;
    raw_in = '0; tp_in = '0; lat_cfg = 9'd20; win_cfg = 4'd5;
    repeat (3) @(negedge clk);
    // reset state: no event, queue empty, no drops (R8, R9, R10)
    chk(ev_valid === 1'b0, "R10", "reset ev_valid", 32'(ev_valid), 0);
    chk(q_full === 1'b0, "R8", "reset q_full", 32'(q_full), 0);
    chk(drop_count === 16'd0, "R9", "reset drop_count", 32'(drop_count), 0);
    rst_n = 1;
    cyc(40);
    accept_now(20, 5); cyc(60);                         // R1 R2 R3 R4 R5 R7
    accept_now(1, 1);  cyc(20);                         // R1 minimum window
    cyc(100); accept_now(100, 15); cyc(120);            // R1 maximum window
    rdy_mode = 1; lat_cfg = 40; win_cfg = 5;            // R8 R9 queue fill
    fire = 1; cyc(7); fire = 0; cyc(400);
    rdy_mode = 0; accept_now(30, 3); rdy_mode = 2; cyc(30); // R10 stall
    rdy_mode = 1; cyc(100); rdy_mode = 0;
    accept_now(25, 6); lat_cfg = 3; win_cfg = 2; cyc(60); // R11
    tick_div = 3; phase = 0; cyc(60);                   // R1 slow ticks
    accept_now(10, 4); cyc(2); accept_now(12, 3); cyc(200);
    tick_div = 1; phase = 0;
    sync_req = 1; cyc(10);                              // R6 orbit sync
    accept_now(n - n_sync, 5); cyc(60);
    for (int i = 0; i < 4000 && bxc != 2; i++) cyc();   // R6 wrap 3563 -> 0
    accept_now(5, 5); cyc(60);
    accept_now(7, 2); cyc(60);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule